// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Word Transfer

This block joins a master and a slave that exchange a single word without a shared transfer clock. Every step of a transfer is started by a level change from the other side. The master and the slave each sample the other's handshake lines through a two-flop synchroniser. The slave can therefore take any number of its own cycles before it answers. The master presents a simple local command port: a start pulse, a direction bit, an address and write data. It returns a one-cycle completion pulse and the word that was read. The slave keeps a small register file as its storage.

On a read, the master puts the address on the link and raises its read request. Once the slave has taken the address, it raises acknowledge. The master then drops its request, and the slave drops acknowledge. After its response delay, the slave drives the word and raises data-ready. The master captures the word and raises its own acknowledge. The slave drops data-ready, and the master then drops its acknowledge. On a write, the address and the data travel together under a write request, and a single acknowledge cycle closes the transfer. The slave's answer delay is the parameter `RESP_DELAY`, counted in cycles.

Top module: `hs_link`

## Requirements
- R1: While reset is low, and right after it is released, `busy`, `done` and `rdata` are 0, and every storage word reads back as 0.
- R2: A write with `wr_en`=1 stores `wdata` at `addr`. A later read of that address returns the value.
- R3: A read places the stored word of `addr` on `rdata` no later than the `done` pulse. `rdata` then holds that value until the next read completes.
- R4: `busy` is 1 from the cycle after an accepted `start` until the transfer completes. `done` is high for exactly one cycle per transfer, and in that cycle `busy` is 0.
- R5: A `start` raised while `busy` is 1 is ignored. It neither changes the transfer in flight nor alters storage, and it produces no extra `done`.
- R6: The read request and the write request are never high together. A request stays high until its synchronised acknowledge is seen, and the slave raises acknowledge only while it sees a request.
- R7: The slave raises data-ready only after its acknowledge is low. When `done` pulses, every handshake line is low, so the next transfer begins from the all-low state.
- R8: Results and `done` counts are the same for `RESP_DELAY` of 0 and of 5.
- R9: A write leaves `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock for both parties |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a transfer when the master is idle |
| wr_en | input | 1 | 1 = write, 0 = read; sampled with `start` |
| addr | input | AW | Word address, sampled with `start` |
| wdata | input | DW | Write word, sampled with `start` |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Word returned by the most recent read |

## Verification
The transfer sequence mixes writes to different addresses, reads of written and unwritten words, an overwrite of a word that was read before, and reads placed directly after writes. Together these separate a wrong storage index, stale read data and a write that disturbs `rdata`. Each step runs at the same time on two copies with response delays of 0 and 5. A transfer that depends on timing instead of on the handshake edges would therefore show up as a mismatch between the copies. Directed cases cover reset contents, a second `start` that arrives mid-transfer, and the exact width of the `done` pulse.

// File: rtl/hs_link.sv
module hs_link #(
  parameter int AW = 3,
  parameter int DW = 8,
  parameter int RESP_DELAY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int CW = $clog2(RESP_DELAY + 2);

  typedef enum logic [2:0] {M_IDLE, M_RREQ, M_RDATA, M_RACK, M_WREQ, M_WEND} mst_t;
  typedef enum logic [2:0] {S_IDLE, S_RWAIT, S_RACK, S_DWAIT, S_DRDY, S_DEND, S_WWAIT, S_WACK} slv_t;

  // link lines
  logic          rd_req, wr_req, m_ack, ack, drdy;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  // synchronisers
  logic [1:0] ack_q, drdy_q, rd_q, wr_q, mack_q;
  logic       ack_s, drdy_s, rd_s, wr_s, mack_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q <= '0; drdy_q <= '0; rd_q <= '0; wr_q <= '0; mack_q <= '0;
    end else begin
      ack_q  <= {ack_q[0], ack};
      drdy_q <= {drdy_q[0], drdy};
      rd_q   <= {rd_q[0], rd_req};
      wr_q   <= {wr_q[0], wr_req};
      mack_q <= {mack_q[0], m_ack};
    end
  end

  assign ack_s  = ack_q[1];
  assign drdy_s = drdy_q[1];
  assign rd_s   = rd_q[1];
  assign wr_s   = wr_q[1];
  assign mack_s = mack_q[1];

  // master
  mst_t m_st;
  assign busy = (m_st != M_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_st <= M_IDLE; rd_req <= 1'b0; wr_req <= 1'b0; m_ack <= 1'b0;
      bus_addr <= '0; bus_wdata <= '0; rdata <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (m_st)
        M_IDLE: if (start) begin
          bus_addr  <= addr;
          bus_wdata <= wdata;
          if (wr_en) begin wr_req <= 1'b1; m_st <= M_WREQ; end
          else       begin rd_req <= 1'b1; m_st <= M_RREQ; end
        end
        M_RREQ:  if (ack_s)   begin rd_req <= 1'b0; m_st <= M_RDATA; end
        M_RDATA: if (drdy_s)  begin rdata <= bus_rdata; m_ack <= 1'b1; m_st <= M_RACK; end
        M_RACK:  if (!drdy_s) begin m_ack <= 1'b0; done <= 1'b1; m_st <= M_IDLE; end
        M_WREQ:  if (ack_s)   begin wr_req <= 1'b0; m_st <= M_WEND; end
        M_WEND:  if (!ack_s)  begin done <= 1'b1; m_st <= M_IDLE; end
        default: m_st <= M_IDLE;
      endcase
    end
  end

  // slave
  slv_t          s_st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] mem [DEPTH];
  logic          cnt_hit;

  assign cnt_hit = (cnt == CW'(RESP_DELAY));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_st <= S_IDLE; cnt <= '0; s_addr <= '0; ack <= 1'b0; drdy <= 1'b0; bus_rdata <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      case (s_st)
        S_IDLE: begin
          cnt <= '0;
          if (rd_s)      s_st <= S_RWAIT;
          else if (wr_s) s_st <= S_WWAIT;
        end
        S_RWAIT: if (cnt_hit) begin
          s_addr <= bus_addr; ack <= 1'b1; cnt <= '0; s_st <= S_RACK;
        end else cnt <= cnt + 1'b1;
        S_RACK: if (!rd_s) begin ack <= 1'b0; s_st <= S_DWAIT; end
        S_DWAIT: if (cnt_hit) begin
          bus_rdata <= mem[s_addr]; drdy <= 1'b1; s_st <= S_DRDY;
        end else cnt <= cnt + 1'b1;
        S_DRDY: if (mack_s)  begin drdy <= 1'b0; s_st <= S_DEND; end
        S_DEND: if (!mack_s) s_st <= S_IDLE;
        S_WWAIT: if (cnt_hit) begin
          mem[bus_addr] <= bus_wdata; ack <= 1'b1; cnt <= '0; s_st <= S_WACK;
        end else cnt <= cnt + 1'b1;
        S_WACK: if (!wr_s) begin ack <= 1'b0; s_st <= S_IDLE; end
        default: s_st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_EXCL:   assert property (@(posedge clk) disable iff (!rst_n) !(rd_req && wr_req)); // R6
  AST_RREQ_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) (rd_req && !ack_s) |=> rd_req); // R6
  AST_WREQ_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) (wr_req && !ack_s) |=> wr_req); // R6
  AST_ACK_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(ack) |-> (rd_s || wr_s)); // R6
  AST_DRDY_NOACK: assert property (@(posedge clk) disable iff (!rst_n) $rose(drdy) |-> !ack); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R4
  AST_DONE_IDLE:  assert property (@(posedge clk) disable iff (!rst_n)
                    done |-> (!rd_req && !wr_req && !m_ack && !ack_s && !drdy_s && !busy)); // R7
endmodule

// File: tb/test_hs_link.sv
module test_hs_link;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, start, wr_en;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic       busy_a, done_a, busy_b, done_b;
  logic [7:0] rdata_a, rdata_b;

  hs_link #(.AW(3), .DW(8), .RESP_DELAY(5)) i_hs_link (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .busy(busy_a), .done(done_a), .rdata(rdata_a));

  hs_link #(.AW(3), .DW(8), .RESP_DELAY(0)) i_hs_link_fast (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .busy(busy_b), .done(done_b), .rdata(rdata_b));

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {wr, addr, data, expected rdata afterwards}
  localparam bit [19:0] VEC [10] = '{
    {1'b1, 3'd3, 8'hA5, 8'h00},
    {1'b1, 3'd7, 8'h3C, 8'h00},
    {1'b0, 3'd3, 8'h00, 8'hA5},
    {1'b0, 3'd7, 8'h00, 8'h3C},
    {1'b0, 3'd0, 8'h00, 8'h00},
    {1'b1, 3'd0, 8'hFF, 8'h00},
    {1'b0, 3'd0, 8'h00, 8'hFF},
    {1'b1, 3'd3, 8'h11, 8'hFF},
    {1'b0, 3'd3, 8'h00, 8'h11},
    {1'b0, 3'd5, 8'h00, 8'h00}
  };

  task automatic kick(input bit w, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    start = 1'b1; wr_en = w; addr = a; wdata = d;
    @(negedge clk);
    start = 1'b0;
    // R4: busy in the cycle after start
    chk(busy_a && busy_b, "R4 busy after start", {busy_a, busy_b}, 2'b11);
  endtask

  task automatic wait_both(input string tag);
    int na = 0, nb = 0, n = 0;
    while (!(na > 0 && nb > 0) && n < 2000) begin
      if (done_a) begin na++; chk(!busy_a, "R4 busy low at done", busy_a, 0); end
      if (done_b) begin nb++; chk(!busy_b, "R4 busy low at done", busy_b, 0); end
      if (!(na > 0 && nb > 0)) begin @(negedge clk); n++; end
    end
    if (n >= 2000) chk(1'b0, {"watchdog ", tag}, n, 0);
    repeat (30) begin
      @(negedge clk);
      if (done_a) na++;
      if (done_b) nb++;
    end
    chk(na == 1 && nb == 1, {"R4 R5 R8 one done per transfer ", tag}, na * 16 + nb, 8'h11);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    // R1: outputs during reset
    chk(!busy_a && !done_a && rdata_a == 0 && !busy_b && !done_b && rdata_b == 0,
        "R1 reset outputs", {busy_a, done_a, rdata_a}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_a && !busy_b && !done_a && !done_b, "R1 after release", {busy_a, busy_b}, 0);
    // R1: storage zero
    kick(1'b0, 3'd2, 8'h00);
    wait_both("R1");
    chk(rdata_a == 0 && rdata_b == 0, "R1 storage zero", rdata_a, 0);

    // R2 R3 R8 R9 table walk
    for (int k = 0; k < 10; k++) begin
      kick(VEC[k][19], VEC[k][18:16], VEC[k][15:8]);
      wait_both("table");
      chk(rdata_a == VEC[k][7:0], VEC[k][19] ? "R9 R2 write keeps rdata" : "R3 R2 read data",
          rdata_a, VEC[k][7:0]);
      chk(rdata_b == VEC[k][7:0], "R8 zero-delay copy matches", rdata_b, VEC[k][7:0]);
    end

    // R5: start during busy ignored
    kick(1'b1, 3'd6, 8'h5A);
    start = 1'b1; wr_en = 1'b1; addr = 3'd6; wdata = 8'h77;
    @(negedge clk);
    start = 1'b0;
    wait_both("R5");
    kick(1'b0, 3'd6, 8'h00);
    wait_both("R5 readback");
    chk(rdata_a == 8'h5A && rdata_b == 8'h5A, "R5 ignored start", rdata_a, 8'h5A);

    // R7: back-to-back transfers start from all-low state
    kick(1'b1, 3'd1, 8'hC3);
    wait_both("R7 a");
    kick(1'b0, 3'd1, 8'h00);
    wait_both("R7 b");
    chk(rdata_a == 8'hC3 && rdata_b == 8'hC3, "R7 back-to-back", rdata_b, 8'hC3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule